// File: doc/BRIEF.md
# Serially Chained Shared Memory Self-Test Wrapper

This block is one self-test wrapper shared by a group of single-port, word-access memories that all have the same data width but may have different depths. The wrapper treats the group as one deep memory. A single combined address counter sweeps the summed depth of all members. The range that the counter currently lies in selects the one member whose chip enable is raised. One pattern generator and one response comparator, each as wide as the common data width, serve every member. Because only one member is active at a time, the peak test power of the group is that of its largest single member.

A controller pulses `bist_start`. The wrapper then runs an eight-operation-per-word march over every background pattern and raises `bist_done` when the run is finished. A sticky `bist_fail`, together with the index and local address of the first miscompare, shows the result. While no test is running, the memory-side ports simply follow the functional-side inputs.

Top module: `mbist_serial_chain`

## Requirements
- R1: When no test is running (after reset, and after a run has finished), `mem_ce`, `mem_we`, `mem_addr` and `mem_wdata` equal `fn_ce`, `fn_we`, `fn_addr` and `fn_wdata`.
- R2: `bist_start` sampled high while idle or finished starts a run. The first test cycle is a write of the value 0 to member 0, local address 0, in the cycle after the sampling edge. A start pulse during a run has no effect.
- R3: In every test cycle exactly one bit of `mem_ce` is high. Member i occupies the combined range [base_i, base_i + depth_i), where base_i is the sum of the depths of the members with a lower index. `mem_addr` equals the combined address minus base_i.
- R4: For each background, the run performs these march elements in this order: ascending write 0; ascending read 0 then write 1; descending read 1 then write 0; ascending read 0 then write 1; ascending read 1. Each cycle performs one operation, and both operations of an element act on one word in consecutive cycles before the address moves on.
- R5: Background k=0 is all zeros. For k of 1 or more, bit i of background k equals bit (k-1) of i; with 8 bits, background 1 is 0xAA. An operation value of 1 means the inverted background. During writes, `mem_wdata` carries that word.
- R6: A run lasts N = 8 × total words × backgrounds test cycles. `bist_done` goes high at the (N+2)-th rising edge, counting the edge that sampled the start, and stays high until the next accepted start.
- R7: The read data of the member selected at a read is compared with the expected word one cycle after the read. A difference sets `bist_fail`, which is already valid when `bist_done` rises.
- R8: `bist_fail` is sticky. `fail_mem` and `fail_addr` hold the member index and local address of the first miscompare. An accepted start clears all three.
- R9: While a run is in progress, the functional inputs have no effect on the memory-side ports.
- R10: With fault-free memories, a run ends with `bist_fail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_start | input | 1 | Start request from the controller |
| bist_done | output | 1 | Run finished, held until the next start |
| bist_fail | output | 1 | Sticky miscompare flag |
| fail_mem | output | IW | Member index of the first miscompare |
| fail_addr | output | LAW | Local address of the first miscompare |
| fn_ce | input | NUM_MEM | Functional chip enables |
| fn_we | input | 1 | Functional write enable |
| fn_addr | input | LAW | Functional word address |
| fn_wdata | input | DATA_W | Functional write data |
| mem_ce | output | NUM_MEM | Chip enable per member |
| mem_we | output | 1 | Shared write enable |
| mem_addr | output | LAW | Shared local word address |
| mem_wdata | output | DATA_W | Shared write data |
| mem_rdata | input | NUM_MEM*DATA_W | Read data of all members, member i in slice i |

## Verification
Several properties are checked on every cycle. These are the one-hot chip enable and in-range combined address during a run, the write of zero to member 0 right after an accepted start, the holding of `bist_done`, the stickiness of the fail record, and the rule that the fail flag only rises after a compare. Other behaviour can only be shown by the bench's scenarios. A scoreboard predicts every memory access of a complete run from the member depths, which covers the exact march order, the address decode, the background words and the indifference to noisy functional inputs and to a start pulse mid-run. It also covers the completion latency and the pass-through in idle. Injected stuck bits at two different members and addresses show that the first failing member and address are reported and that a new start clears them.

// File: rtl/mbist_chain_pkg.sv
package mbist_chain_pkg;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FLUSH, PH_DONE} phase_e;
    typedef enum logic [2:0] {EL_W0, EL_R0W1, EL_R1W0, EL_R0W1B, EL_R1} elem_e;

    // member depth exponent i, 4 bits per member in a 64-bit vector
    function automatic int unsigned aw_of(logic [63:0] vec, int unsigned i);
        return int'(vec[i*4 +: 4]);
    endfunction

    function automatic int unsigned base_of(logic [63:0] vec, int unsigned i);
        int unsigned s = 0;
        for (int unsigned j = 0; j < i; j++) s += (1 << aw_of(vec, j));
        return s;
    endfunction

    function automatic int unsigned max_aw(logic [63:0] vec, int unsigned n);
        int unsigned m = 1;
        for (int unsigned j = 0; j < n; j++) if (aw_of(vec, j) > m) m = aw_of(vec, j);
        return m;
    endfunction

    function automatic logic elem_two(elem_e e);
        return (e != EL_W0) && (e != EL_R1);
    endfunction

    function automatic logic elem_down(elem_e e);
        return e == EL_R1W0;
    endfunction

    function automatic logic op_read(elem_e e, logic sub);
        return (e == EL_R1) || (elem_two(e) && !sub);
    endfunction

    // value 1 means inverted background
    function automatic logic op_val(elem_e e, logic sub);
        case (e)
            EL_W0:             return 1'b0;
            EL_R0W1, EL_R0W1B: return sub;
            EL_R1W0:           return !sub;
            default:           return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/mbist_march_seq.sv
module mbist_march_seq
    import mbist_chain_pkg::*;
#(
    parameter int unsigned TOTAL  = 88,
    parameter int unsigned NUM_BG = 2,
    localparam int unsigned AW = (TOTAL > 2) ? $clog2(TOTAL) : 1,
    localparam int unsigned BW = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          launch,
    output logic          op_valid,
    output logic          op_rd,
    output logic          op_v,
    output logic [AW-1:0] op_addr,
    output logic [BW-1:0] op_bg,
    output logic          active,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        elem_e         elem;
        logic          sub;
        logic [AW-1:0] addr;
        logic [BW-1:0] bg;
    } seq_t;

    seq_t q, d;
    logic last_sub, last_addr;

    always_comb begin
        d         = q;
        launch    = start && (q.phase == PH_IDLE || q.phase == PH_DONE);
        last_sub  = !elem_two(q.elem) || q.sub;
        last_addr = elem_down(q.elem) ? (q.addr == '0) : (q.addr == AW'(TOTAL - 1));
        case (q.phase)
            PH_RUN: begin
                if (!last_sub) begin
                    d.sub = 1'b1;
                end else begin
                    d.sub = 1'b0;
                    if (!last_addr) begin
                        d.addr = elem_down(q.elem) ? q.addr - 1'b1 : q.addr + 1'b1;
                    end else if (q.elem != EL_R1) begin
                        d.elem = elem_e'(q.elem + 3'd1);
                        d.addr = elem_down(d.elem) ? AW'(TOTAL - 1) : '0;
                    end else if (q.bg != BW'(NUM_BG - 1)) begin
                        d.bg   = q.bg + 1'b1;
                        d.elem = EL_W0;
                        d.addr = '0;
                    end else begin
                        d.phase = PH_FLUSH;
                    end
                end
            end
            PH_FLUSH: d.phase = PH_DONE;
            default: if (launch) begin
                d.phase = PH_RUN;
                d.elem  = EL_W0;
                d.sub   = 1'b0;
                d.addr  = '0;
                d.bg    = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, elem: EL_W0, sub: 1'b0, addr: '0, bg: '0};
        else        q <= d;
    end

    assign op_valid = (q.phase == PH_RUN);
    assign op_rd    = op_read(q.elem, q.sub);
    assign op_v     = op_val(q.elem, q.sub);
    assign op_addr  = q.addr;
    assign op_bg    = q.bg;
    assign active   = (q.phase == PH_RUN) || (q.phase == PH_FLUSH);
    assign done     = (q.phase == PH_DONE);

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (32'(op_addr) < TOTAL));
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: rtl/mbist_chain_decode.sv
module mbist_chain_decode
    import mbist_chain_pkg::*;
#(
    parameter int unsigned NUM_MEM = 4,
    parameter logic [63:0] AW_VEC  = 64'h3545,
    parameter int unsigned AW      = 7,
    localparam int unsigned LAW = max_aw(AW_VEC, NUM_MEM),
    localparam int unsigned IW  = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
    input  logic [AW-1:0]      addr,
    output logic [NUM_MEM-1:0] hit,
    output logic [LAW-1:0]     local_addr,
    output logic [IW-1:0]      idx
);
    logic [31:0] addr_ext;
    logic [31:0] base_arr [NUM_MEM];
    assign addr_ext = 32'(addr);

    for (genvar i = 0; i < NUM_MEM; i++) begin : g_range
        localparam int unsigned B = base_of(AW_VEC, i);
        localparam int unsigned D = 1 << aw_of(AW_VEC, i);
        assign base_arr[i] = B;
        assign hit[i] = (addr_ext >= B) && (addr_ext < B + D);
    end

    always_comb begin
        local_addr = '0;
        idx        = '0;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (hit[i]) begin
                local_addr = LAW'(addr_ext - base_arr[i]);
                idx        = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mbist_resp_check.sv
module mbist_resp_check #(
    parameter int unsigned NUM_MEM = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned LAW     = 5,
    parameter int unsigned IW      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      rd_issue,
    input  logic [DATA_W-1:0]         exp_word,
    input  logic [IW-1:0]             rd_idx,
    input  logic [LAW-1:0]            rd_addr,
    input  logic [NUM_MEM*DATA_W-1:0] rdata_bus,
    output logic                      fail,
    output logic [IW-1:0]             fail_idx,
    output logic [LAW-1:0]            fail_addr
);
    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] word;
        logic [IW-1:0]     idx;
        logic [LAW-1:0]    addr;
        logic              fail;
        logic [IW-1:0]     f_idx;
        logic [LAW-1:0]    f_addr;
    } chk_t;

    chk_t q, d;
    logic [DATA_W-1:0] got;
    logic miss;

    always_comb begin
        d     = q;
        got   = rdata_bus[32'(q.idx) * DATA_W +: DATA_W];
        miss  = q.pend && (got != q.word);
        d.pend = rd_issue;
        d.word = exp_word;
        d.idx  = rd_idx;
        d.addr = rd_addr;
        if (clear) begin
            d.fail   = 1'b0;
            d.f_idx  = '0;
            d.f_addr = '0;
        end else if (miss && !q.fail) begin
            d.fail   = 1'b1;
            d.f_idx  = q.idx;
            d.f_addr = q.addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fail      = q.fail;
    assign fail_idx  = q.f_idx;
    assign fail_addr = q.f_addr;

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> (fail && $stable(fail_idx) && $stable(fail_addr)));
    assert_fail_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(q.pend));
endmodule

// File: rtl/mbist_serial_chain.sv
module mbist_serial_chain
    import mbist_chain_pkg::*;
#(
    parameter int unsigned NUM_MEM = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_BG  = 2,
    parameter logic [63:0] AW_VEC  = 64'h3545,
    localparam int unsigned LAW   = max_aw(AW_VEC, NUM_MEM),
    localparam int unsigned IW    = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
    localparam int unsigned TOTAL = base_of(AW_VEC, NUM_MEM),
    localparam int unsigned CAW   = (TOTAL > 2) ? $clog2(TOTAL) : 1,
    localparam int unsigned BW    = (NUM_BG > 1) ? $clog2(NUM_BG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bist_start,
    output logic                      bist_done,
    output logic                      bist_fail,
    output logic [IW-1:0]             fail_mem,
    output logic [LAW-1:0]            fail_addr,
    input  logic [NUM_MEM-1:0]        fn_ce,
    input  logic                      fn_we,
    input  logic [LAW-1:0]            fn_addr,
    input  logic [DATA_W-1:0]         fn_wdata,
    output logic [NUM_MEM-1:0]        mem_ce,
    output logic                      mem_we,
    output logic [LAW-1:0]            mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [NUM_MEM*DATA_W-1:0] mem_rdata
);
    logic           launch, op_valid, op_rd, op_v, active;
    logic [CAW-1:0] op_addr;
    logic [BW-1:0]  op_bg;
    logic [NUM_MEM-1:0] hit;
    logic [LAW-1:0] loc;
    logic [IW-1:0]  idx;
    logic [DATA_W-1:0] word;

    function automatic logic [DATA_W-1:0] bg_word(int unsigned k);
        logic [DATA_W-1:0] w;
        for (int unsigned i = 0; i < DATA_W; i++)
            w[i] = (k == 0) ? 1'b0 : 1'((i >> (k - 1)) & 1);
        return w;
    endfunction

    mbist_march_seq #(.TOTAL(TOTAL), .NUM_BG(NUM_BG)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(bist_start), .launch(launch),
        .op_valid(op_valid), .op_rd(op_rd), .op_v(op_v), .op_addr(op_addr),
        .op_bg(op_bg), .active(active), .done(bist_done)
    );

    mbist_chain_decode #(.NUM_MEM(NUM_MEM), .AW_VEC(AW_VEC), .AW(CAW)) u_dec (
        .addr(op_addr), .hit(hit), .local_addr(loc), .idx(idx)
    );

    assign word = bg_word(32'(op_bg)) ^ {DATA_W{op_v}};

    mbist_resp_check #(.NUM_MEM(NUM_MEM), .DATA_W(DATA_W), .LAW(LAW), .IW(IW)) u_chk (
        .clk(clk), .rst_n(rst_n), .clear(launch), .rd_issue(op_valid && op_rd),
        .exp_word(word), .rd_idx(idx), .rd_addr(loc), .rdata_bus(mem_rdata),
        .fail(bist_fail), .fail_idx(fail_mem), .fail_addr(fail_addr)
    );

    always_comb begin
        if (active) begin
            mem_ce    = op_valid ? hit : '0;
            mem_we    = op_valid && !op_rd;
            mem_addr  = loc;
            mem_wdata = word;
        end else begin
            mem_ce    = fn_ce;
            mem_we    = fn_we;
            mem_addr  = fn_addr;
            mem_wdata = fn_wdata;
        end
    end

    assert_one_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ($countones(mem_ce) == 1));
    assert_first_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (mem_we && mem_ce[0] && (mem_addr == '0) && (mem_wdata == '0)));
endmodule

// File: tb/sim_mbist_serial_chain.sv
module sim_mbist_serial_chain;
    localparam int NM = 4;
    localparam int DEP [NM] = '{32, 16, 32, 8};
    localparam int TOT = 88;
    localparam int N = 8 * TOT * 2;

    typedef struct packed {
        logic [3:0] ce;
        logic       we;
        logic [4:0] addr;
        logic [7:0] wdata;
    } item_t;

    logic clk = 0, rst_n = 0, bist_start = 0;
    logic bist_done, bist_fail, mem_we, fn_we = 0;
    logic [1:0] fail_mem;
    logic [4:0] fail_addr, mem_addr, fn_addr = 0;
    logic [3:0] fn_ce = 0, mem_ce;
    logic [7:0] fn_wdata = 0, mem_wdata;
    logic [31:0] mem_rdata;
    logic [7:0] marr [NM][32];
    int total = 0, bad = 0;
    bit in_bist = 0;
    bit f_en = 0, f_val = 0;
    int f_mem = 0, f_addr = 0, f_bit = 0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    mbist_serial_chain u0 (.*);

    // memory models with synchronous read and an optional stuck bit
    always @(posedge clk) begin
        for (int i = 0; i < NM; i++) begin
            if (mem_ce[i]) begin
                if (mem_we) marr[i][mem_addr] <= mem_wdata;
                else begin
                    logic [7:0] v;
                    v = marr[i][mem_addr];
                    if (f_en && i == f_mem && int'(mem_addr) == f_addr) v[f_bit] = f_val;
                    mem_rdata[i*8 +: 8] <= v;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] bgw(int k);
        return (k == 0) ? 8'h00 : 8'hAA;
    endfunction

    // driver: predicted access list of one complete run (R3 R4 R5)
    task automatic push_march();
        for (int bg = 0; bg < 2; bg++)
            for (int e = 0; e < 5; e++)
                for (int s = 0; s < TOT; s++) begin
                    int a, m, la, nops;
                    a = (e == 2) ? TOT - 1 - s : s;
                    m = 0; la = a;
                    while (la >= DEP[m]) begin la -= DEP[m]; m++; end
                    nops = (e == 0 || e == 4) ? 1 : 2;
                    for (int k = 0; k < nops; k++) begin
                        item_t it;
                        bit rd, v;
                        rd = (e == 4) || (nops == 2 && k == 0);
                        v = (e == 0) ? 0 : (e == 2) ? (k == 0) : (e == 4) ? 1 : (k == 1);
                        it.ce = 4'(1 << m); it.we = !rd; it.addr = 5'(la);
                        it.wdata = bgw(bg) ^ {8{v}};
                        exp_q.push_back(it);
                    end
                end
    endtask

    // monitor: pops one prediction per active memory cycle
    always @(negedge clk) begin
        if (in_bist && mem_ce != 0) begin
            if (exp_q.size() == 0) chk(0, "R4 unexpected op", int'(mem_ce), 0);
            else begin
                item_t e;
                e = exp_q.pop_front();
                chk(mem_ce == e.ce && mem_we == e.we && mem_addr == e.addr &&
                    (!e.we || mem_wdata == e.wdata), "R3 R4 R5 R9 access",
                    int'({mem_ce, mem_we, mem_addr, mem_wdata}),
                    int'({e.ce, e.we, e.addr, e.wdata}));
            end
        end
    end

    task automatic run(bit poke, bit exp_fail, int e_mem, int e_addr);
        int k;
        push_march();
        @(negedge clk) bist_start = 1;
        @(posedge clk) k = 1;
        @(negedge clk) bist_start = 0;
        in_bist = 1;
        chk(bist_fail == 0 && bist_done == 0, "R8 clear on start", int'(bist_fail), 0);
        while (!bist_done) begin
            fn_ce = 4'($urandom); fn_we = 1'($urandom);
            fn_addr = 5'($urandom); fn_wdata = 8'($urandom);
            bist_start = poke && (k == 100);
            @(posedge clk) k++;
            @(negedge clk);
        end
        in_bist = 0;
        bist_start = 0;
        fn_ce = 0;
        chk(k == N + 2, "R6 done latency", k, N + 2);
        chk(exp_q.size() == 0, "R4 R6 op count", exp_q.size(), 0);
        chk(bist_fail == exp_fail, "R7 R10 fail flag", int'(bist_fail), int'(exp_fail));
        if (exp_fail) begin
            chk(int'(fail_mem) == e_mem, "R8 fail member", int'(fail_mem), e_mem);
            chk(int'(fail_addr) == e_addr, "R8 fail address", int'(fail_addr), e_addr);
        end
        repeat (3) @(negedge clk);
        chk(bist_done == 1, "R6 done held", int'(bist_done), 1);
    endtask

    task automatic passthru(string tag, logic [3:0] c, logic w, logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        fn_ce = c; fn_we = w; fn_addr = a; fn_wdata = d;
        #1;
        chk(mem_ce == c && mem_we == w && mem_addr == a && mem_wdata == d, tag,
            int'({mem_ce, mem_we, mem_addr, mem_wdata}), int'({c, w, a, d}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bist_done == 0 && bist_fail == 0, "R6 R8 reset state",
            int'({bist_done, bist_fail}), 0);
        passthru("R1 idle pattern a", 4'b0001, 1, 5'd3, 8'h5A);
        rst_n = 1;
        passthru("R1 idle pattern b", 4'b1010, 0, 5'd31, 8'hC3);
        passthru("R1 idle pattern c", 4'b0000, 1, 5'd0, 8'hFF);
        // R2 R9 R10: clean run, noisy functional inputs, start pulse mid-run
        run(1, 0, 0, 0);
        passthru("R1 after done", 4'b0100, 1, 5'd17, 8'h81);
        // R7 R8: stuck-at-1 on bit 0 of member 1, local 5
        f_en = 1; f_mem = 1; f_addr = 5; f_bit = 0; f_val = 1;
        run(0, 1, 1, 5);
        // R7 R8: stuck-at-0 on bit 3 of member 3, local 7
        f_mem = 3; f_addr = 7; f_bit = 3; f_val = 0;
        run(0, 1, 3, 7);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule